// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base for a two-channel pulse-width modulator. A 16-bit counter advances once per prescaled tick. The tick comes from two dividers in series. The first divides by 1 or by an even number from 2 to 14. The second divides by a power of two from 1 to 128. The counter counts up, counts down, counts up then down, or stays frozen, as selected by a control word. It publishes its value, its direction, and one-clock strobes when it arrives at zero or at the active period.

The period is held in two registers. Software writes land in a shadow copy. Depending on a control bit, a write either reaches the active period only when the counter next arrives at zero, or replaces the active period at once. A debug-halt input can freeze counting at once, let the counter finish its cycle and stop at zero, or be ignored.

The control word is written whole through a one-cycle write strobe. Its field positions are fixed: mode in bits 1:0, period-load select in bit 3, the first divider in bits 9:7, the second divider in bits 12:10, and the halt behaviour in bits 15:14.

Top module: `pwm_timebase`

## Requirements
- R1: While `srst` is high, and on the first clock after it falls, `cnt_o` is 0, `cnt_up_o` is 1, and both event strobes are 0. Reset sets both period registers to 0 and the mode to freeze, so the counter does not move until the control word is written.
- R2: The counter advances once every F clocks, where F = A * 2^C. C is control bits 12:10. A is 1 when control bits 9:7 are 0, and otherwise A is twice their value.
- R3: With mode 00 (up), each tick adds 1. When the counter is at or above the active period, the next tick returns it to 0. `cnt_up_o` is 1.
- R4: With mode 01 (down), each tick subtracts 1. When the counter is at 0, the next tick loads the active period. `cnt_up_o` is 0.
- R5: With mode 10 (up-down), the counter rises to the active period, then falls to 0, then rises again. `cnt_up_o` shows the current direction. With a period of 0, the counter stays at 0.
- R6: With mode 11 (freeze), the counter and the direction hold their values.
- R7: With control bit 3 at 0, a period write goes to the shadow register only. The active period takes the shadow value on the tick that brings the counter to 0.
- R8: With control bit 3 at 1, a period write also becomes the active period on the next clock. If it arrives in the same clock as a shadow transfer, the write wins.
- R9: `zero_evt_o` and `prd_evt_o` are high for exactly the clock in which a tick has just moved the counter to 0 (for `zero_evt_o`) or to the active period (for `prd_evt_o`). They are never high without such a tick.
- R10: With control bits 15:14 at 00, `halt_i` high stops the counter from the next clock.
- R11: With control bits 15:14 at 01, `halt_i` high lets the counter keep counting until it reaches 0. It then holds at 0 while `halt_i` stays high.
- R12: With control bits 15:14 at 11 or 10, `halt_i` has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 16 | Control word value |
| prd_wr_i | input | 1 | Write strobe for the period |
| prd_wdata_i | input | CNT_W | Period value |
| halt_i | input | 1 | Debug halt request |
| cnt_o | output | CNT_W | Counter value |
| cnt_up_o | output | 1 | 1 while counting up |
| zero_evt_o | output | 1 | Counter-reached-zero strobe |
| prd_evt_o | output | 1 | Counter-reached-period strobe |

## Verification
The up mode is run with a period of 5 at divide-by-one. This separates an off-by-one at the wrap point, and the event counts over a fixed window show whether each strobe fires once per cycle. A period of 0 with three different divider settings isolates the prescaler. It tells an error in the even-divide stage apart from an error in the power-of-two stage, because only one stage is non-trivial in two of the three settings. Down counting at divide-by-two, and up-down counting with periods 4, 0 and 3, exercise the reload, the turning points and the degenerate zero period. Shadow writes issued just after a zero event show that the old period still governs the cycle in progress. The three halt settings are each tried with halt raised in mid-count, which tells an immediate stop apart from a finish-the-cycle stop.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int CTL_W  = 16;
    localparam int HDIV_W = 3;
    localparam int CDIV_W = 3;

    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDN   = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        HALT_NOW       = 2'b00,
        HALT_CYCLE_END = 2'b01,
        HALT_RSVD      = 2'b10,
        HALT_IGNORE    = 2'b11
    } halt_mode_e;

    typedef struct packed {
        halt_mode_e          halt;
        logic [CDIV_W-1:0]   cdiv;
        logic [HDIV_W-1:0]   hdiv;
        logic                imm_ld;
        cnt_mode_e           mode;
    } tb_ctl_t;

    localparam tb_ctl_t CTL_RST = '{
        halt:   HALT_NOW,
        cdiv:   '0,
        hdiv:   '0,
        imm_ld: 1'b0,
        mode:   CM_FREEZE
    };

    // Field positions are fixed by the control word layout.
    function automatic tb_ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
        tb_ctl_t c;
        c.mode   = cnt_mode_e'(w[1:0]);
        c.imm_ld = w[3];
        c.hdiv   = w[9:7];
        c.cdiv   = w[12:10];
        c.halt   = halt_mode_e'(w[15:14]);
        return c;
    endfunction

endpackage

// File: rtl/pwm_ctl_reg.sv
module pwm_ctl_reg
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output tb_ctl_t          ctl_o
);
    tb_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) ctl_d = unpack_ctl(wdata_i);
    end

    always_ff @(posedge clk) begin
        if (srst) ctl_q <= CTL_RST;
        else      ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/pwm_div_stage.sv
module pwm_div_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         en_i,
    input  logic [W-1:0] last_i,
    output logic         term_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt >= last_i);
        if (en_i) begin
            if (at_last) st_d.cnt = '0;
            else         st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign term_o = en_i && at_last;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_tb_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic [HDIV_W-1:0] hdiv_i,
    input  logic [CDIV_W-1:0] cdiv_i,
    output logic              tick_o
);
    localparam int S1_W = HDIV_W + 1;
    localparam int S2_W = (1 << CDIV_W) - 1;

    logic [S1_W-1:0] last1;
    logic [S2_W-1:0] last2;
    logic            s1_term;

    always_comb begin
        if (hdiv_i == '0) last1 = '0;
        else              last1 = {hdiv_i, 1'b0} - 1'b1;
        last2 = (S2_W'(1) << cdiv_i) - 1'b1;
    end

    pwm_div_stage #(.W(S1_W)) u_hs (
        .clk(clk), .srst(srst), .en_i(1'b1), .last_i(last1), .term_o(s1_term)
    );

    pwm_div_stage #(.W(S2_W)) u_pw (
        .clk(clk), .srst(srst), .en_i(s1_term), .last_i(last2), .term_o(tick_o)
    );
endmodule

// File: rtl/pwm_period_buf.sv
module pwm_period_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         imm_i,
    input  logic         zero_load_i,
    output logic [W-1:0] prd_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zero_load_i) st_d.active = st_q.shadow;
        if (wr_i) begin
            st_d.shadow = wdata_i;
            if (imm_i) st_d.active = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign prd_o = st_q.active;
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         tick_i,
    input  cnt_mode_e    mode_i,
    input  halt_mode_e   halt_sel_i,
    input  logic         halt_i,
    input  logic [W-1:0] prd_i,
    output logic [W-1:0] cnt_o,
    output logic         up_o,
    output logic         zero_evt_o,
    output logic         prd_evt_o,
    output logic         zero_load_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
        logic         ez;
        logic         ep;
    } st_t;

    st_t  st_d, st_q;
    logic hold, step;

    always_comb begin
        st_d = st_q;
        unique case (halt_sel_i)
            HALT_NOW:       hold = halt_i;
            HALT_CYCLE_END: hold = halt_i && (st_q.cnt == '0);
            default:        hold = 1'b0;
        endcase
        step = tick_i && (mode_i != CM_FREEZE) && !hold;

        if (step) begin
            unique case (mode_i)
                CM_UP: begin
                    st_d.up  = 1'b1;
                    st_d.cnt = (st_q.cnt >= prd_i) ? '0 : st_q.cnt + 1'b1;
                end
                CM_DOWN: begin
                    st_d.up  = 1'b0;
                    st_d.cnt = (st_q.cnt == '0) ? prd_i : st_q.cnt - 1'b1;
                end
                CM_UPDN: begin
                    if (st_q.up) begin
                        if (st_q.cnt >= prd_i) begin
                            st_d.up  = 1'b0;
                            st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.up  = 1'b1;
                            st_d.cnt = (prd_i == '0) ? '0 : W'(1);
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        st_d.ez = step && (st_d.cnt == '0);
        st_d.ep = step && (st_d.cnt == prd_i);
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '{cnt: '0, up: 1'b1, ez: 1'b0, ep: 1'b0};
        else      st_q <= st_d;
    end

    assign cnt_o       = st_q.cnt;
    assign up_o        = st_q.up;
    assign zero_evt_o  = st_q.ez;
    assign prd_evt_o   = st_q.ep;
    assign zero_load_o = st_d.ez;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             ctl_wr_i,
    input  logic [15:0]      ctl_wdata_i,
    input  logic             prd_wr_i,
    input  logic [CNT_W-1:0] prd_wdata_i,
    input  logic             halt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_up_o,
    output logic             zero_evt_o,
    output logic             prd_evt_o
);
    tb_ctl_t          ctl;
    logic             tick;
    logic             zero_load;
    logic [CNT_W-1:0] prd_act;

    pwm_ctl_reg u_ctl (
        .clk(clk), .srst(srst), .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i), .ctl_o(ctl)
    );

    pwm_prescaler u_psc (
        .clk(clk), .srst(srst), .hdiv_i(ctl.hdiv), .cdiv_i(ctl.cdiv), .tick_o(tick)
    );

    pwm_period_buf #(.W(CNT_W)) u_prd (
        .clk(clk), .srst(srst), .wr_i(prd_wr_i), .wdata_i(prd_wdata_i),
        .imm_i(ctl.imm_ld), .zero_load_i(zero_load), .prd_o(prd_act)
    );

    pwm_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .srst(srst), .tick_i(tick), .mode_i(ctl.mode),
        .halt_sel_i(ctl.halt), .halt_i(halt_i), .prd_i(prd_act),
        .cnt_o(cnt_o), .up_o(cnt_up_o), .zero_evt_o(zero_evt_o),
        .prd_evt_o(prd_evt_o), .zero_load_o(zero_load)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         srst,
    input  tb_ctl_t      ctl,
    input  logic         halt_i,
    input  logic         prd_wr_i,
    input  logic [W-1:0] prd_wdata_i,
    input  logic [W-1:0] prd_act,
    input  logic [W-1:0] cnt_o,
    input  logic         zero_evt_o,
    input  logic         prd_evt_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        srst |=> (cnt_o == '0 && !zero_evt_o && !prd_evt_o));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (srst)
        (ctl.mode == CM_UP) |=>
            (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (ctl.mode == CM_FREEZE) |=> $stable(cnt_o));

    // R8
    imm_load_chk: assert property (@(posedge clk) disable iff (srst)
        (prd_wr_i && ctl.imm_ld) |=> (prd_act == $past(prd_wdata_i)));

    // R9
    zero_evt_chk: assert property (@(posedge clk) disable iff (srst)
        zero_evt_o |-> (cnt_o == '0));

    // R9
    prd_evt_chk: assert property (@(posedge clk) disable iff (srst)
        prd_evt_o |-> (cnt_o == $past(prd_act)));

    // R10
    halt_now_chk: assert property (@(posedge clk) disable iff (srst)
        (halt_i && ctl.halt == HALT_NOW) |=> $stable(cnt_o));
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .srst(srst), .ctl(ctl), .halt_i(halt_i),
    .prd_wr_i(prd_wr_i), .prd_wdata_i(prd_wdata_i), .prd_act(prd_act),
    .cnt_o(cnt_o), .zero_evt_o(zero_evt_o), .prd_evt_o(prd_evt_o)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic         ctl_wr = 1'b0;
    logic [15:0]  ctl_wdata = '0;
    logic         prd_wr = 1'b0;
    logic [W-1:0] prd_wdata = '0;
    logic         halt = 1'b0;
    logic [W-1:0] cnt;
    logic         up, zev, pev;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    cmp_en = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    pwm_timebase #(.CNT_W(W)) i_pwm_timebase (
        .clk(clk), .srst(srst), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .prd_wr_i(prd_wr), .prd_wdata_i(prd_wdata), .halt_i(halt),
        .cnt_o(cnt), .cnt_up_o(up), .zero_evt_o(zev), .prd_evt_o(pev)
    );

    // Behavioural reference model
    int m_cnt, m_up, m_ez, m_ep, m_sh, m_act;
    int m_mode, m_ld, m_hs, m_cd, m_run, m_p1, m_p2;

    always @(posedge clk) begin
        int n1, n2, nc, nu, na;
        bit tk, hold, go;
        if (srst) begin
            m_cnt = 0; m_up = 1; m_ez = 0; m_ep = 0; m_sh = 0; m_act = 0;
            m_mode = 3; m_ld = 0; m_hs = 0; m_cd = 0; m_run = 0; m_p1 = 0; m_p2 = 0;
        end else begin
            n1 = (m_hs == 0) ? 1 : 2 * m_hs;
            n2 = 1 << m_cd;
            tk = (m_p1 >= n1 - 1) && (m_p2 >= n2 - 1);
            if (m_p1 >= n1 - 1) begin
                m_p1 = 0;
                m_p2 = (m_p2 >= n2 - 1) ? 0 : m_p2 + 1;
            end else m_p1++;
            hold = halt && ((m_run == 0) || (m_run == 1 && m_cnt == 0));
            go = tk && m_mode != 3 && !hold;
            nc = m_cnt; nu = m_up;
            if (go) begin
                if (m_mode == 0) begin
                    nu = 1; nc = (m_cnt >= m_act) ? 0 : m_cnt + 1;
                end else if (m_mode == 1) begin
                    nu = 0; nc = (m_cnt == 0) ? m_act : m_cnt - 1;
                end else if (m_up == 1) begin
                    if (m_cnt >= m_act) begin nu = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nu = 1; nc = (m_act == 0) ? 0 : 1; end
                    else nc = m_cnt - 1;
                end
            end
            m_ez = (go && nc == 0) ? 1 : 0;
            m_ep = (go && nc == m_act) ? 1 : 0;
            na = m_act;
            if (go && nc == 0) na = m_sh;
            if (prd_wr) begin
                if (m_ld == 1) na = int'(prd_wdata);
                m_sh = int'(prd_wdata);
            end
            m_act = na; m_cnt = nc; m_up = nu;
            if (ctl_wr) begin
                m_mode = int'(ctl_wdata[1:0]); m_ld = int'(ctl_wdata[3]);
                m_hs = int'(ctl_wdata[9:7]); m_cd = int'(ctl_wdata[12:10]);
                m_run = int'(ctl_wdata[15:14]);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(tag, "cnt", int'(cnt), m_cnt);
            chk(tag, "dir", int'(up), m_up);
            chk(tag, "zero_evt", int'(zev), m_ez);
            chk(tag, "prd_evt", int'(pev), m_ep);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input int mode, input int ld, input int hs, input int cd, input int rm);
        ctl_wdata = {rm[1:0], 1'b0, cd[2:0], hs[2:0], 3'b000, ld[0], 1'b0, mode[1:0]};
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_prd(input int v);
        prd_wdata = v[W-1:0];
        prd_wr = 1'b1;
        @(negedge clk);
        prd_wr = 1'b0;
    endtask

    task automatic wait_zev;
        do @(negedge clk); while (!zev);
    endtask

    task automatic measure(input string req, input int exp);
        int n = 0;
        wait_zev();
        wait_zev();
        do begin @(negedge clk); n++; end while (!zev);
        chk(req, "tick interval", n, exp);
    endtask

    initial begin
        int v, nz, np, mx;
        run(3);
        srst = 1'b0;
        @(negedge clk);
        cmp_en = 1'b1;
        chk("R1", "reset cnt", int'(cnt), 0);
        chk("R1", "reset dir", int'(up), 1);
        chk("R1", "reset evts", int'(zev) + int'(pev), 0);
        tag = "R6";
        run(10);
        chk("R6", "frozen after reset", int'(cnt), 0);

        tag = "R8";
        wr_ctl(0, 1, 0, 0, 3);
        wr_prd(5);
        run(20);
        tag = "R3";
        run(30);
        tag = "R9";
        nz = 0; np = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            nz += int'(zev); np += int'(pev);
        end
        chk("R9", "zero events in 60", nz, 10);
        chk("R9", "period events in 60", np, 10);

        tag = "R2";
        wr_ctl(0, 1, 3, 2, 3);
        wr_prd(0);
        measure("R2", 24);
        wr_ctl(0, 1, 5, 0, 3);
        measure("R2", 10);
        wr_ctl(0, 1, 0, 3, 3);
        measure("R2", 8);

        tag = "R4";
        wr_ctl(1, 1, 1, 0, 3);
        wr_prd(7);
        run(80);

        tag = "R5";
        wr_ctl(2, 1, 0, 1, 3);
        wr_prd(4);
        run(80);
        wr_prd(0);
        run(20);
        wr_prd(3);
        run(40);

        tag = "R7";
        wr_ctl(0, 0, 0, 0, 3);
        wr_prd(3);
        wait_zev();
        wr_prd(12);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt) > mx) mx = int'(cnt); end while (!zev);
        chk("R7", "peak before shadow load", mx, 3);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt) > mx) mx = int'(cnt); end while (!zev);
        chk("R7", "peak after shadow load", mx, 12);

        tag = "R6";
        wr_ctl(3, 1, 0, 0, 3);
        v = int'(cnt);
        run(15);
        chk("R6", "frozen count", int'(cnt), v);

        tag = "R10";
        wr_ctl(0, 1, 0, 0, 0);
        wr_prd(20);
        run(7);
        halt = 1'b1;
        @(negedge clk);
        v = int'(cnt);
        run(10);
        chk("R10", "held on halt", int'(cnt), v);
        halt = 1'b0;
        run(3);
        chk("R10", "resumes after halt", (int'(cnt) != v) ? 1 : 0, 1);

        tag = "R11";
        wr_ctl(0, 1, 0, 0, 1);
        run(3);
        halt = 1'b1;
        run(40);
        chk("R11", "stopped at zero", int'(cnt), 0);
        run(10);
        chk("R11", "stays at zero", int'(cnt), 0);
        halt = 1'b0;
        run(3);

        tag = "R12";
        wr_ctl(0, 1, 0, 0, 3);
        halt = 1'b1;
        @(negedge clk);
        v = int'(cnt);
        run(5);
        chk("R12", "free run 11 ignores halt", (int'(cnt) != v) ? 1 : 0, 1);
        wr_ctl(0, 1, 0, 0, 2);
        v = int'(cnt);
        run(5);
        chk("R12", "free run 10 ignores halt", (int'(cnt) != v) ? 1 : 0, 1);
        halt = 1'b0;
        run(5);

        cmp_en = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", tag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule